// File: doc/BRIEF.md
# Byte-Lane Inversion Codec

This block sits between a memory controller and a low-power DRAM data bus. It reduces the number of data lines driven high. On the outgoing (write) path it examines each 8-bit lane of a multi-byte word. Any lane with five or more one bits is complemented before it is sent. A companion flag bit for that lane is raised, so no lane ever drives more than four lines high.

On the incoming (read) path the block undoes the transformation. Each lane whose flag bit is set is complemented back to its original value.

The two directions have independent enables. With the write enable off, words leave untouched and with all flags low. With the read enable off, incoming flags are disregarded and data passes through as received. Both paths are registered with one cycle of latency, and the number of byte lanes is a parameter.

Top module: `byte_invert_codec`

## Requirements
- R1: `encValid` rises exactly one clock after `wrValid`, and `decValid` exactly one clock after `rdValid`; both are low when the matching input valid was low.
- R2: While `rstN` is low, and in the first cycle after it, all outputs (`encValid`, `encData`, `encFlag`, `decValid`, `decData`) are zero.
- R3: With `wrInvEn` high, a lane (bits [8i+7:8i] of `wrData`) holding five or more one bits is output complemented on `encData` with `encFlag[i]` = 1, so that lane carries at most four one bits.
- R4: With `wrInvEn` high, a lane holding four or fewer one bits, the tie case of exactly four included, is output unchanged with `encFlag[i]` = 0.
- R5: With `wrInvEn` low, `encData` equals the accepted `wrData` and every `encFlag` bit is 0, whatever the weight of each lane.
- R6: With `rdInvEn` high, lane i of `decData` is the complement of lane i of `rdData` when `rdFlag[i]` = 1, and equal to it when `rdFlag[i]` = 0.
- R7: With `rdInvEn` low, `rdFlag` has no effect: `decData` equals the accepted `rdData`.
- R8: When an input valid is low, the matching data and flag outputs keep their previous values.
- R9: Feeding the encoder output (data and flags) into the decoder with both enables high returns the original byte, for every one of the 256 byte values.
- R10: Each lane is encoded and decoded on its own weight and flag only, independent of the other lanes in the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrInvEn | input | 1 | Inversion enable for the write (encode) path |
| wrValid | input | 1 | Write word valid |
| wrData | input | LANES*8 | Write word to encode |
| encValid | output | 1 | Encoded word valid |
| encData | output | LANES*8 | Encoded word for the bus |
| encFlag | output | LANES | Per-lane inversion flag, bit i for lane i |
| rdInvEn | input | 1 | Inversion enable for the read (decode) path |
| rdValid | input | 1 | Read word valid |
| rdData | input | LANES*8 | Word received from the bus |
| rdFlag | input | LANES | Received per-lane inversion flags |
| decValid | output | 1 | Decoded word valid |
| decData | output | LANES*8 | Restored word |

## Verification
The bench targets the weight boundary between four and five one bits. A design that treats exactly four as heavy would raise the flag on a tie. A design that compares against the wrong threshold would leave five-bit lanes uninverted and break the four-line ceiling.

Words that mix heavy and light lanes expose any mix-up of lane indices. Such a design would flag or complement the wrong byte.

With each enable off, the bench drives heavy lanes and set flags. A design that ignored the enables would still invert them. An exhaustive round trip over all byte values catches any asymmetry between the encoder and the decoder. Idle cycles with changing inputs catch outputs that fail to hold.

// File: rtl/byte_invert_pkg.sv
`timescale 1ns/1ps
package byte_invert_pkg;

  localparam int LANE_BITS     = 8;
  localparam int HEAVY_WEIGHT  = 5;  // lanes at or above this weight get inverted
  localparam int WEIGHT_W      = $clog2(LANE_BITS + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;

  function automatic logic [WEIGHT_W-1:0] laneWeight(input logic [LANE_BITS-1:0] b);
    logic [WEIGHT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < LANE_BITS; k++) acc = acc + WEIGHT_W'(b[k]);
    return acc;
  endfunction

endpackage

// File: rtl/byte_invert_ctrl.sv
`timescale 1ns/1ps
module byte_invert_ctrl
  import byte_invert_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                       wrInvEn,
  input  logic                       wrValid,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  input  logic                       rdInvEn,
  input  logic                       rdValid,
  input  logic [LANES-1:0]           rdFlag,
  output strobe_t                    strb,
  output logic [LANES-1:0]           encMask,
  output logic [LANES-1:0]           decMask
);

  logic [LANES-1:0] heavy;

  for (genvar g = 0; g < LANES; g++) begin : g_weigh
    logic [WEIGHT_W-1:0] weight;
    assign weight   = laneWeight(wrData[g*LANE_BITS +: LANE_BITS]);
    assign heavy[g] = (weight >= WEIGHT_W'(HEAVY_WEIGHT));
  end

  always_comb begin
    strb.encLoad = wrValid;
    strb.decLoad = rdValid;
    encMask      = wrInvEn ? heavy  : '0;
    decMask      = rdInvEn ? rdFlag : '0;
  end

endmodule

// File: rtl/byte_invert_datapath.sv
`timescale 1ns/1ps
module byte_invert_datapath
  import byte_invert_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [LANES-1:0]           encMask,
  input  logic [LANES-1:0]           decMask,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  input  logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       encValid,
  output logic [LANES*LANE_BITS-1:0] encData,
  output logic [LANES-1:0]           encFlag,
  output logic                       decValid,
  output logic [LANES*LANE_BITS-1:0] decData
);

  localparam int DATA_W = LANES * LANE_BITS;

  logic [DATA_W-1:0] encNext;
  logic [DATA_W-1:0] decNext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign encNext[g*LANE_BITS +: LANE_BITS] =
      wrData[g*LANE_BITS +: LANE_BITS] ^ {LANE_BITS{encMask[g]}};
    assign decNext[g*LANE_BITS +: LANE_BITS] =
      rdData[g*LANE_BITS +: LANE_BITS] ^ {LANE_BITS{decMask[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encValid <= 1'b0;
      encData  <= '0;
      encFlag  <= '0;
    end else begin
      encValid <= strb.encLoad;
      if (strb.encLoad) begin
        encData <= encNext;
        encFlag <= encMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decData  <= '0;
    end else begin
      decValid <= strb.decLoad;
      if (strb.decLoad) decData <= decNext;
    end
  end

endmodule

// File: rtl/byte_invert_codec.sv
`timescale 1ns/1ps
module byte_invert_codec
  import byte_invert_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrInvEn,
  input  logic                       wrValid,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  output logic                       encValid,
  output logic [LANES*LANE_BITS-1:0] encData,
  output logic [LANES-1:0]           encFlag,
  input  logic                       rdInvEn,
  input  logic                       rdValid,
  input  logic [LANES*LANE_BITS-1:0] rdData,
  input  logic [LANES-1:0]           rdFlag,
  output logic                       decValid,
  output logic [LANES*LANE_BITS-1:0] decData
);

  strobe_t          strb;
  logic [LANES-1:0] encMask;
  logic [LANES-1:0] decMask;

  byte_invert_ctrl #(.LANES(LANES)) ctrl_i (
    .wrInvEn (wrInvEn),
    .wrValid (wrValid),
    .wrData  (wrData),
    .rdInvEn (rdInvEn),
    .rdValid (rdValid),
    .rdFlag  (rdFlag),
    .strb    (strb),
    .encMask (encMask),
    .decMask (decMask)
  );

  byte_invert_datapath #(.LANES(LANES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .encMask  (encMask),
    .decMask  (decMask),
    .wrData   (wrData),
    .rdData   (rdData),
    .encValid (encValid),
    .encData  (encData),
    .encFlag  (encFlag),
    .decValid (decValid),
    .decData  (decData)
  );

endmodule

// File: rtl/byte_invert_codec_chk.sv
`timescale 1ns/1ps
module byte_invert_codec_chk
  import byte_invert_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrInvEn,
  input logic                       wrValid,
  input logic [LANES*LANE_BITS-1:0] wrData,
  input logic                       encValid,
  input logic [LANES*LANE_BITS-1:0] encData,
  input logic [LANES-1:0]           encFlag,
  input logic                       rdInvEn,
  input logic                       rdValid,
  input logic [LANES*LANE_BITS-1:0] rdData,
  input logic [LANES-1:0]           rdFlag,
  input logic                       decValid,
  input logic [LANES*LANE_BITS-1:0] decData
);

  p_enc_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> encValid);
  p_enc_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !encValid);
  p_dec_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> decValid);

  p_flags_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrInvEn) |=> (encFlag == '0));

  p_dec_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdInvEn) |=> (decData == $past(rdData)));

  p_enc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> ($stable(encData) && $stable(encFlag)));
  p_dec_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> $stable(decData));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    p_ones_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
      (wrValid && wrInvEn) |=> ($countones(encData[g*LANE_BITS +: LANE_BITS]) <= 4));
    p_recover_r9: assert property (@(posedge clk) disable iff (!rstN)
      wrValid |=> ((encData[g*LANE_BITS +: LANE_BITS] ^ {LANE_BITS{encFlag[g]}})
                   == $past(wrData[g*LANE_BITS +: LANE_BITS])));
  end

endmodule

bind byte_invert_codec byte_invert_codec_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/byte_invert_codec_tb.sv
`timescale 1ns/1ps
module byte_invert_codec_tb_top;

  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrInvEn, wrValid, rdInvEn, rdValid;
  logic [DATA_W-1:0] wrData, rdData;
  logic [LANES-1:0]  rdFlag;
  logic              encValid, decValid;
  logic [DATA_W-1:0] encData, decData;
  logic [LANES-1:0]  encFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the outputs
  logic              mEncValid, mDecValid;
  logic [DATA_W-1:0] mEncData, mDecData;
  logic [LANES-1:0]  mEncFlag;

  always #2.5 clk = ~clk;

  byte_invert_codec #(.LANES(LANES)) dut_i (
    .clk(clk), .rstN(rstN),
    .wrInvEn(wrInvEn), .wrValid(wrValid), .wrData(wrData),
    .encValid(encValid), .encData(encData), .encFlag(encFlag),
    .rdInvEn(rdInvEn), .rdValid(rdValid), .rdData(rdData), .rdFlag(rdFlag),
    .decValid(decValid), .decData(decData)
  );

  function automatic int ones8(input logic [7:0] b);
    int n = 0;
    for (int k = 0; k < 8; k++) if (b[k]) n++;
    return n;
  endfunction

  function automatic logic [LANES-1:0] expFlags(input logic [DATA_W-1:0] d, input logic en);
    logic [LANES-1:0] f;
    for (int i = 0; i < LANES; i++) f[i] = en && (ones8(d[i*8 +: 8]) > 4);
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] applyFlags(input logic [DATA_W-1:0] d,
                                                   input logic [LANES-1:0] f);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = f[i] ? ~d[i*8 +: 8] : d[i*8 +: 8];
    return r;
  endfunction

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compareAll(input string encReq, input string decReq);
    checkVal("R1 encValid", 64'(encValid), 64'(mEncValid));
    checkVal("R1 decValid", 64'(decValid), 64'(mDecValid));
    checkVal({encReq, " encData"}, 64'(encData), 64'(mEncData));
    checkVal({encReq, " encFlag"}, 64'(encFlag), 64'(mEncFlag));
    checkVal({decReq, " decData"}, 64'(decData), 64'(mDecData));
  endtask

  task automatic step(input logic wv, input logic wen, input logic [DATA_W-1:0] wd,
                      input logic rv, input logic ren, input logic [DATA_W-1:0] rd,
                      input logic [LANES-1:0] rf,
                      input string encReq, input string decReq);
    @(negedge clk);
    wrValid = wv; wrInvEn = wen; wrData = wd;
    rdValid = rv; rdInvEn = ren; rdData = rd; rdFlag = rf;
    mEncValid = wv;
    mDecValid = rv;
    if (wv) begin
      mEncFlag = expFlags(wd, wen);
      mEncData = applyFlags(wd, mEncFlag);
    end
    if (rv) mDecData = applyFlags(rd, ren ? rf : '0);
    @(posedge clk);
    #1;
    compareAll(encReq, decReq);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] keepEnc;
    logic [LANES-1:0]  keepFlag;
    rstN = 1'b0;
    wrValid = 0; wrInvEn = 0; wrData = '0;
    rdValid = 0; rdInvEn = 0; rdData = '0; rdFlag = '0;
    mEncValid = 0; mDecValid = 0; mEncData = '0; mDecData = '0; mEncFlag = '0;
    repeat (3) @(posedge clk);
    #1;
    compareAll("R2", "R2");  // R2: reset state
    @(negedge clk);
    rstN = 1'b1;

    // R3 / R4 / R10: tie of four, five, full, empty in one word
    step(1, 1, 32'hFF_1F_0F_00, 0, 0, '0, '0, "R3/R4/R10", "R8");
    step(1, 1, 32'h00_F8_3C_FF, 0, 0, '0, '0, "R3/R4/R10", "R8");
    // R5: heavy lanes pass untouched when write enable is off
    step(1, 0, 32'hFF_FE_F8_0F, 0, 0, '0, '0, "R5", "R8");
    // R8: idle cycle with changing inputs holds outputs
    step(0, 1, 32'h12_34_56_78, 0, 1, 32'hAA_55_AA_55, 4'hF, "R8", "R8");
    // R6: selective decode by flag
    step(0, 0, '0, 1, 1, 32'hF0_0F_A5_5A, 4'b1010, "R8", "R6/R10");
    // R7: flags ignored when read enable is off
    step(0, 0, '0, 1, 0, 32'hC3_3C_99_66, 4'hF, "R8", "R7");
    step(0, 0, 32'hFFFF_FFFF, 0, 0, 32'h0, 4'h0, "R8", "R8");

    // R9: every byte value round-trips through encoder then decoder
    for (int v = 0; v < 256; v++) begin
      logic [DATA_W-1:0] word;
      word = {LANES{8'(v)}} ^ {8'h00, 8'hFF, 8'h00, 8'hFF};
      step(1, 1, word, 0, 1, '0, '0, "R9 enc", "R8");
      keepEnc  = encData;
      keepFlag = encFlag;
      step(0, 1, '0, 1, 1, keepEnc, keepFlag, "R8", "R9 dec");
      checkVal("R9 roundtrip", 64'(decData), 64'(word));
    end

    // Random mix, fixed seed
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom,
           LANES'($urandom), "R3/R4/R5 rand", "R6/R7 rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule